// File: doc/BRIEF.md
# Post-Update Store Address Unit

This block is the store execution stage of a single-issue 64-bit core for stores that update their base register afterwards. It accepts one decoded store at a time. Each store has a size of 1, 2, 4 or 8 bytes and one of three addressing forms. The block issues a memory write at the base register value exactly as it arrived. In the same transaction it returns the displacement-adjusted effective address for writing back into the base register. So the base register moves forward after the access instead of before it.

A small state machine sequences the work. In `ST_IDLE` the unit is ready and waits for `op_valid`. On an aligned operation it takes `T_ACCEPT` into `ST_ISSUE`. On a misaligned one it takes `T_REJECT` into `ST_FAULT`. `ST_ISSUE` holds the write request until the memory side accepts it, then takes `T_DONE` back to `ST_IDLE`. `ST_FAULT` lasts one cycle and takes `T_RECOVER` back to `ST_IDLE`. The unit changes no condition or status state. It reports only the write request, the base-register writeback and the one-cycle fault flag.

Top module: `psu_store_unit`

## Requirements
- R1: After reset, `op_ready` is 1 and `mem_valid`, `wb_valid` and `fault` are 0.
- R2: `mem_addr` equals the `base_val` captured at acceptance, never the effective address.
- R3: With `op_form` = 0 (displacement), the effective address is `base_val` plus `imm` sign-extended from 16 bits.
- R4: With `op_form` = 1 (scaled displacement), the effective address is `base_val` plus the sign extension of {`imm[13:0]`, 2'b00}. `imm[15:14]` has no effect.
- R5: With `op_form` = 2 or 3 (indexed), the effective address is `base_val` plus `index_val`, and `imm` has no effect.
- R6: The address addition wraps modulo 2^64 and gives no overflow indication.
- R7: `op_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The low bytes of `src_val` are placed little-endian starting at byte lane `base_val[2:0]`, where lane k is `mem_data[8k+7:8k]`. `mem_strb[k]` is set exactly for the written lanes, and all other lanes of `mem_data` are zero.
- R8: An access whose address is not a multiple of its size is not issued. `fault` is high for exactly the following cycle, no writeback occurs, and the unit then returns to ready.
- R9: While a request waits for `mem_ready`, `op_ready` is 0, the request fields stay stable, and `op_valid` has no effect.
- R10: `wb_valid` is high exactly in the cycle where `mem_valid` and `mem_ready` are both high, with `wb_data` equal to the effective address. Each issued store gives exactly one such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| op_form | input | 2 | 0 displacement, 1 scaled displacement, 2/3 indexed |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| src_val | input | 64 | Store source value |
| imm | input | 16 | Displacement field |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Write address (old base) |
| mem_data | output | 64 | Lane-steered write data |
| mem_strb | output | 8 | Byte-lane strobes |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_data | output | 64 | Effective address to write back |
| fault | output | 1 | Misaligned operation rejected |

## Verification
The assertions assume that `op_size` never asks for 8 bytes at a data width below 64. They also assume that the memory side may hold `mem_ready` low for any number of cycles, but does not depend on seeing a request before it raises ready. The stimulus sweeps every size, form and low-address offset. It holds `mem_ready` low for zero to two cycles before each acceptance and keeps `op_valid` asserted with garbage operands during some stalls. Each operation completes before the next one is offered, so `op_valid` never overlaps a completing handshake.

// File: rtl/psu_pkg.sv
package psu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        FM_DISP   = 2'd0,
        FM_SCALED = 2'd1,
        FM_INDEX  = 2'd2,
        FM_INDEX2 = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } state_e;
endpackage

// File: rtl/psu_ea_calc.sv
module psu_ea_calc #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int DS_W   = 14
) (
    input  psu_pkg::form_e    form,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    input  logic [DISP_W-1:0] imm,
    output logic [XLEN-1:0]   ea
);
    localparam int DS_PAD = XLEN - DS_W - 2;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] scaled_ext;
    logic [XLEN-1:0] addend;

    assign disp_ext   = {{(XLEN-DISP_W){imm[DISP_W-1]}}, imm};
    assign scaled_ext = {{DS_PAD{imm[DS_W-1]}}, imm[DS_W-1:0], 2'b00};

    always_comb begin
        unique case (form)
            psu_pkg::FM_DISP:   addend = disp_ext;
            psu_pkg::FM_SCALED: addend = scaled_ext;
            default:            addend = index;
        endcase
    end

    // modulo 2^XLEN, carry dropped
    assign ea = base + addend;
endmodule

// File: rtl/psu_lane_steer.sv
module psu_lane_steer #(
    parameter int XLEN = 64
) (
    input  psu_pkg::size_e      size,
    input  logic [$clog2(XLEN/8)-1:0] off,
    input  logic [XLEN-1:0]     src,
    output logic [XLEN-1:0]     data,
    output logic [XLEN/8-1:0]   strb,
    output logic                aligned
);
    localparam int NBYTES = XLEN / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    logic [OFF_W:0]      nbytes;
    logic [NBYTES-1:0]   lane_en;

    assign nbytes  = (OFF_W+1)'(1) << size;
    assign aligned = ((off & OFF_W'(nbytes - 1'b1)) == '0);

    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_lane
            logic [OFF_W-1:0] src_idx;
            assign lane_en[i] = (OFF_W+1)'(i) < nbytes;
            assign strb[i]    = (OFF_W'(i) >= off) && lane_en[OFF_W'(i) - off];
            assign src_idx    = OFF_W'(i) - off;
            assign data[8*i +: 8] = strb[i] ? src[8*src_idx +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/psu_store_unit.sv
module psu_store_unit #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int DS_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_size,
    input  logic [1:0]        op_form,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [XLEN-1:0]   src_val,
    input  logic [DISP_W-1:0] imm,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_data,
    output logic [XLEN/8-1:0] mem_strb,
    output logic              wb_valid,
    output logic [XLEN-1:0]   wb_data,
    output logic              fault
);
    import psu_pkg::*;

    localparam int NBYTES = XLEN / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    state_e state_q, state_d;

    logic [XLEN-1:0]   ea_w;
    logic [XLEN-1:0]   data_w;
    logic [NBYTES-1:0] strb_w;
    logic              aligned_w;
    logic              accept;

    logic [XLEN-1:0]   addr_q, ea_q, data_q;
    logic [NBYTES-1:0] strb_q;

    psu_ea_calc #(.XLEN(XLEN), .DISP_W(DISP_W), .DS_W(DS_W)) u_ea (
        .form  (form_e'(op_form)),
        .base  (base_val),
        .index (index_val),
        .imm   (imm),
        .ea    (ea_w)
    );

    psu_lane_steer #(.XLEN(XLEN)) u_steer (
        .size    (size_e'(op_size)),
        .off     (base_val[OFF_W-1:0]),
        .src     (src_val),
        .data    (data_w),
        .strb    (strb_w),
        .aligned (aligned_w)
    );

    assign accept = op_valid && (state_q == ST_IDLE);

    // next-state logic: T_ACCEPT, T_REJECT, T_DONE, T_RECOVER
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) state_d = aligned_w ? ST_ISSUE : ST_FAULT;
            end
            ST_ISSUE: begin
                if (mem_ready) state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            ea_q    <= '0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept && aligned_w) begin
                addr_q <= base_val;
                ea_q   <= ea_w;
                data_q <= data_w;
                strb_q <= strb_w;
            end
        end
    end

    // outputs
    always_comb begin
        op_ready  = 1'b0;
        mem_valid = 1'b0;
        wb_valid  = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            ST_IDLE:  op_ready = 1'b1;
            ST_ISSUE: begin
                mem_valid = 1'b1;
                wb_valid  = mem_ready;
            end
            ST_FAULT: fault = 1'b1;
            default:  op_ready = 1'b0;
        endcase
        mem_addr = addr_q;
        mem_data = data_q;
        mem_strb = strb_q;
        wb_data  = ea_q;
    end
endmodule

module psu_store_unit_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_data,
    input logic [XLEN/8-1:0] mem_strb,
    input logic              wb_valid,
    input logic [XLEN-1:0]   wb_data,
    input logic              fault
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_data) && $stable(mem_strb) && $stable(wb_data));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && op_ready));

    // R10
    wb_with_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid == (mem_valid && mem_ready));

    // R8
    fault_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_valid && !wb_valid && !op_ready);

    // R8
    fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R7
    strb_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_strb) == 1 || $countones(mem_strb) == 2
            || $countones(mem_strb) == 4 || $countones(mem_strb) == 8));

    // R8
    issued_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_addr[2:0] & 3'($countones(mem_strb) - 1)) == 3'd0));

    // R10
    accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready |=> mem_valid || fault);
endmodule

bind psu_store_unit psu_store_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_strb  (mem_strb),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .fault     (fault)
);

// File: tb/psu_store_unit_bench.sv
module psu_store_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_size = '0;
    logic [1:0]  op_form = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [63:0] src_val = '0;
    logic [15:0] imm = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_addr;
    logic [63:0] mem_data;
    logic [7:0]  mem_strb;
    logic        wb_valid;
    logic [63:0] wb_data;
    logic        fault;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psu_store_unit u_psu_store_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_size(op_size), .op_form(op_form), .base_val(base_val),
        .index_val(index_val), .src_val(src_val), .imm(imm),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_strb(mem_strb), .wb_valid(wb_valid),
        .wb_data(wb_data), .fault(fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ea(input logic [1:0] f, input logic [63:0] b,
                                           input logic [63:0] x, input logic [15:0] d);
        logic [63:0] dd;
        if (f == 2'd0) dd = {{48{d[15]}}, d};
        else if (f == 2'd1) dd = {{48{d[13]}}, d[13:0], 2'b00};
        else dd = x;
        return b + dd;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [1:0] fm, input logic [63:0] b,
                          input logic [63:0] x, input logic [63:0] s, input logic [15:0] d,
                          input int stall, input string tag);
        int nb;
        bit al;
        logic [63:0] e_data, e_ea;
        logic [7:0] e_strb;
        nb = 1 << sz;
        al = (b[2:0] % nb) == 0;
        e_ea = exp_ea(fm, b, x, d);
        e_strb = 8'((16'(1) << nb) - 1) << b[2:0];
        e_data = '0;
        for (int k = 0; k < 8; k++)
            if (e_strb[k]) e_data[8*k +: 8] = s[8*(k - b[2:0]) +: 8];
        @(negedge clk);
        op_size = sz; op_form = fm; base_val = b; index_val = x; src_val = s; imm = d;
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        if (!al) begin
            chk({"R8 fault ", tag}, 64'(fault), 64'd1);
            chk({"R8 no issue ", tag}, 64'({mem_valid, wb_valid}), 64'd0);
            @(negedge clk);
            chk({"R8 recover ", tag}, 64'({op_ready, fault}), 64'b10);
            return;
        end
        chk({"R2 addr ", tag}, mem_addr, b);
        chk({"R7 strb ", tag}, 64'(mem_strb), 64'(e_strb));
        chk({"R7 data ", tag}, mem_data, e_data);
        for (int w = 0; w < stall; w++) begin
            op_valid = 1'b1; base_val = ~b; imm = ~d; src_val = ~s;
            chk({"R9 stall ", tag}, 64'({mem_valid, op_ready, wb_valid}), 64'b100);
            @(negedge clk);
            op_valid = 1'b0;
            chk({"R9 held addr ", tag}, mem_addr, b);
            chk({"R9 held data ", tag}, mem_data, e_data);
        end
        mem_ready = 1'b1;
        #1;
        chk({"R10 wb_valid ", tag}, 64'(wb_valid), 64'd1);
        if (fm == 2'd0) chk({"R3 ea ", tag}, wb_data, e_ea);
        else if (fm == 2'd1) chk({"R4 ea ", tag}, wb_data, e_ea);
        else chk({"R5 ea ", tag}, wb_data, e_ea);
        @(negedge clk);
        mem_ready = 1'b0;
        chk({"R10 single ", tag}, 64'({mem_valid, wb_valid, op_ready}), 64'b001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 reset", 64'({op_ready, mem_valid, wb_valid, fault}), 64'b1000);
        for (int sz = 0; sz < 4; sz++)
            for (int fm = 0; fm < 4; fm++)
                for (int off = 0; off < 8; off++) begin
                    logic [63:0] b;
                    logic [63:0] x;
                    logic [15:0] d;
                    b = 64'h0123_4567_89AB_CD00 + 64'(sz * 4096 + fm * 256) + 64'(off);
                    x = (off % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FF00 : 64'h0000_0000_0010_0040;
                    d = (off % 2 == 1) ? 16'hC3F8 : 16'h3124;
                    run_op(2'(sz), 2'(fm), b, x, 64'hF1E2_D3C4_B5A6_9788 ^ 64'(off * 17),
                           d, (sz + off) % 3, $sformatf("sz%0d fm%0d off%0d", sz, fm, off));
                end
        // R6 wrap cases
        run_op(2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 64'h1122_3344_5566_7788,
               16'h0010, 1, "R6 disp wrap");
        run_op(2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 64'hAABB_CCDD,
               16'h7FFF, 0, "R6 index wrap");
        run_op(2'd1, 2'd1, 64'h0000_0000_0000_0002, 64'd0, 64'hBEEF,
               16'h3FFF, 2, "R6 scaled underflow");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule